// File: doc/BRIEF.md
# Split-Tag Translation Buffer with Refill Control

This block is a direct-mapped address translation buffer that sits between a requester and memory. Each request carries a virtual address, an access kind (load, store or instruction fetch) and a snapshot of the privilege level, the modify-privilege field and the bare-translation flag from the status register. Every entry has three independent tags, one for each access kind, and one physical page base that all three share. A request hits only when the tag for its own kind matches the full virtual page number. On a hit the physical address is returned one cycle after the request is accepted.

On a miss the block works out which permission bit the access needs. In a bypass mode it builds an identity entry itself. Otherwise it asks an external page-table walker for a leaf entry and stalls the requester until the walker answers. It then checks the entry against the needed permission. On failure it reports an access fault tagged with the access kind and leaves every tag alone. On success it writes the page base and fills each tag according to the entry's permission bits. The store tag is filled only when the access that caused the refill was itself a store, so a later store to a page first reached by a load must refill. A flush input invalidates every tag.

The controller has four states. IDLE accepts a request. PROBE compares tags. WALK waits on the walker. FILL checks permissions, writes the arrays and answers. The transitions are:

- accept: IDLE to PROBE when `req_valid` is high.
- hit: PROBE to IDLE, answering with the translated address.
- bypass: PROBE to FILL, with the identity entry.
- miss: PROBE to WALK.
- walked: WALK to FILL when `walk_done` is high.
- finish: FILL to IDLE, answering with either the address or a fault.

Top module: `split_tlb`

## Requirements
- R1: A request's entry is its virtual page number (VPN) modulo ENTRIES. It hits when the tag array selected by its kind (kind 0 load, 1 store, 2 fetch) holds the full VPN. A hit answers in the cycle after acceptance, with no walker request.
- R2: A flush invalidates every load, store and instruction tag, so that the next request to any page misses.
- R3: A store needs supervisor-write (entry bit 5) when privilege is supervisor (1), or when privilege is machine (3) and modify-privilege is supervisor. Otherwise it needs user-write (bit 2). A load follows the same rule with supervisor-read (bit 4) and user-read (bit 1).
- R4: A fetch needs supervisor-execute (bit 6) only when privilege is supervisor, and user-execute (bit 3) otherwise, whatever modify-privilege holds.
- R5: Translation is bypassed, with no walker request, when the bare flag is set, or when privilege is machine and either modify-privilege is machine or the access is a fetch.
- R6: In bypass the entry is identity-mapped, with valid (bit 0) and both execute bits set. Both read bits and both write bits are added only when the bare flag is set, or privilege is not machine, or modify-privilege is machine.
- R7: An entry that lacks the valid bit or the needed permission bit produces a response with `resp_fault` high and `resp_fault_kind` equal to the access kind. No tag is written, so a repeat of the same access misses again.
- R8: On a successful refill the shared base is written. The load tag takes the VPN if either read bit is set, and the instruction tag takes it if either execute bit is set. Otherwise each is invalidated.
- R9: On a successful refill the store tag takes the VPN only if a write bit is set and the access is a store. In every other case it is invalidated.
- R10: The physical address is the page base (entry bits above PG_SHIFT) concatenated with the page offset of the virtual address.
- R11: `walk_req` stays high, with `walk_vaddr` equal to the request address, until `walk_done`. A returned entry of zero is treated as invalid and faults.
- R12: After reset `req_ready` is high and `resp_valid` and `walk_req` are low. `req_ready` stays low from acceptance through the cycle of the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate every tag |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | High when a request can be accepted |
| req_vaddr | input | ADDR_W | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| st_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| st_mprv | input | 2 | Modify-privilege field, same encoding |
| st_bare | input | 1 | Translation mode is bare |
| resp_valid | output | 1 | Response strobe |
| resp_paddr | output | ADDR_W | Translated physical address |
| resp_fault | output | 1 | Access fault |
| resp_fault_kind | output | 2 | Kind of the faulting access |
| walk_req | output | 1 | Walker request |
| walk_vaddr | output | ADDR_W | Address to walk |
| walk_done | input | 1 | Walker has answered |
| walk_pte | input | ADDR_W | Leaf entry returned by the walker (zero on failure) |

## Verification
The bench builds the block with ADDR_W = 24, PG_SHIFT = 12 and ENTRIES = 4. This gives 12-bit page numbers, so the all-ones page number can be tested against the invalid tag pattern, and with four entries pages 0x000, 0x004 and 0x010 all fall into one entry and evict one another. With this configuration the bench sweeps all three access kinds over every combination of privilege, modify-privilege and the bare flag, and each access is repeated so that both the refill and the hit are seen. A walker model in the bench returns entries whose permission bits are computed from the page number and that include invalid and zero entries. A reference model in the bench, written from the requirements, predicts the hit or miss, the number of walks, the physical address and the fault kind for every access, including the effect of the flushes placed between the status combinations.

// File: rtl/stlb_pkg.sv
package stlb_pkg;

    // access kinds
    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    // privilege encoding
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // flag bit positions in a leaf entry
    localparam int FB_V  = 0;
    localparam int FB_UR = 1;
    localparam int FB_UW = 2;
    localparam int FB_UX = 3;
    localparam int FB_SR = 4;
    localparam int FB_SW = 5;
    localparam int FB_SX = 6;

    // tag array slots
    localparam int N_KINDS   = 3;
    localparam int SLOT_LOAD = 0;
    localparam int SLOT_STOR = 1;
    localparam int SLOT_INSN = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_WALK  = 2'd2,
        ST_FILL  = 2'd3
    } tlb_state_e;

endpackage

// File: rtl/stlb_perm.sv
module stlb_perm
    import stlb_pkg::*;
#(
    parameter int VPN_W  = 52,
    parameter int FLAG_W = 12
) (
    input  logic [1:0]        kind,
    input  logic [1:0]        priv,
    input  logic [1:0]        mprv,
    input  logic              bare,
    input  logic [VPN_W-1:0]  vpn,
    output logic [FLAG_W-1:0] need,
    output logic              bypass,
    output logic [VPN_W-1:0]  syn_ppn,
    output logic [FLAG_W-1:0] syn_flags
);
    logic is_sup;
    logic is_mach;
    logic data_sup;

    always_comb begin
        is_sup   = (priv == PRIV_S);
        is_mach  = (priv == PRIV_M);
        data_sup = is_sup || (is_mach && mprv == PRIV_S);

        need = '0;
        if (kind == ACC_STORE) begin
            need[data_sup ? FB_SW : FB_UW] = 1'b1;
        end else if (kind == ACC_FETCH) begin
            need[is_sup ? FB_SX : FB_UX] = 1'b1;
        end else begin
            need[data_sup ? FB_SR : FB_UR] = 1'b1;
        end

        bypass = bare || (is_mach && (mprv == PRIV_M || kind == ACC_FETCH));

        syn_ppn          = vpn;
        syn_flags        = '0;
        syn_flags[FB_V]  = 1'b1;
        syn_flags[FB_UX] = 1'b1;
        syn_flags[FB_SX] = 1'b1;
        if (bare || !is_mach || mprv == PRIV_M) begin
            syn_flags[FB_UR] = 1'b1;
            syn_flags[FB_SR] = 1'b1;
            syn_flags[FB_UW] = 1'b1;
            syn_flags[FB_SW] = 1'b1;
        end
    end

endmodule

// File: rtl/stlb_tag_array.sv
module stlb_tag_array #(
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 53,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             wr_keep,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] wr_tag,
    output logic [TAG_W-1:0] rd_tag
);
    logic [TAG_W-1:0] tags [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tags[i] <= '1;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) tags[i] <= '1;
        end else if (wr_en) begin
            tags[idx] <= wr_keep ? wr_tag : '1;
        end
    end

    assign rd_tag = tags[idx];

endmodule

// File: rtl/stlb_base_array.sv
module stlb_base_array #(
    parameter int ENTRIES = 256,
    parameter int PPN_W   = 52,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [PPN_W-1:0] wr_ppn,
    output logic [PPN_W-1:0] rd_ppn
);
    logic [PPN_W-1:0] bases [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) bases[idx] <= wr_ppn;
    end

    assign rd_ppn = bases[idx];

endmodule

// File: rtl/split_tlb.sv
module split_tlb
    import stlb_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int PG_SHIFT = 12,
    parameter int ENTRIES  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        st_priv,
    input  logic [1:0]        st_mprv,
    input  logic              st_bare,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic              resp_fault,
    output logic [1:0]        resp_fault_kind,
    output logic              walk_req,
    output logic [ADDR_W-1:0] walk_vaddr,
    input  logic              walk_done,
    input  logic [ADDR_W-1:0] walk_pte
);
    localparam int VPN_W  = ADDR_W - PG_SHIFT;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int TAG_W  = VPN_W + 1;
    localparam int FLAG_W = PG_SHIFT;

    tlb_state_e state_q, state_d;

    logic [ADDR_W-1:0] vaddr_q;
    logic [1:0]        kind_q;
    logic [1:0]        priv_q;
    logic [1:0]        mprv_q;
    logic              bare_q;
    logic [VPN_W-1:0]  ppn_q;
    logic [FLAG_W-1:0] flags_q;

    logic [VPN_W-1:0]  vpn_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  probe_tag;
    logic [PG_SHIFT-1:0] off_q;

    logic [FLAG_W-1:0] need;
    logic              bypass;
    logic [VPN_W-1:0]  syn_ppn;
    logic [FLAG_W-1:0] syn_flags;

    logic [TAG_W-1:0]  rd_tag [N_KINDS];
    logic [N_KINDS-1:0] keep;
    logic [VPN_W-1:0]  base_rd;
    logic              hit;
    logic              fill_ok;
    logic              wr_en;

    assign vpn_q     = vaddr_q[ADDR_W-1:PG_SHIFT];
    assign off_q     = vaddr_q[PG_SHIFT-1:0];
    assign idx_q     = IDX_W'(vpn_q % ENTRIES);
    assign probe_tag = {1'b0, vpn_q};

    stlb_perm #(
        .VPN_W  (VPN_W),
        .FLAG_W (FLAG_W)
    ) u_perm (
        .kind      (kind_q),
        .priv      (priv_q),
        .mprv      (mprv_q),
        .bare      (bare_q),
        .vpn       (vpn_q),
        .need      (need),
        .bypass    (bypass),
        .syn_ppn   (syn_ppn),
        .syn_flags (syn_flags)
    );

    // qualification of each tag on a successful refill
    always_comb begin
        keep[SLOT_LOAD] = flags_q[FB_UR] | flags_q[FB_SR];
        keep[SLOT_STOR] = (flags_q[FB_UW] | flags_q[FB_SW]) && (kind_q == ACC_STORE);
        keep[SLOT_INSN] = flags_q[FB_UX] | flags_q[FB_SX];
    end

    assign fill_ok = flags_q[FB_V] && ((flags_q & need) != '0);
    assign wr_en   = (state_q == ST_FILL) && fill_ok;

    for (genvar g = 0; g < N_KINDS; g++) begin : g_tags
        stlb_tag_array #(
            .ENTRIES (ENTRIES),
            .TAG_W   (TAG_W),
            .IDX_W   (IDX_W)
        ) u_tags (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .wr_en   (wr_en),
            .wr_keep (keep[g]),
            .idx     (idx_q),
            .wr_tag  (probe_tag),
            .rd_tag  (rd_tag[g])
        );
    end

    stlb_base_array #(
        .ENTRIES (ENTRIES),
        .PPN_W   (VPN_W),
        .IDX_W   (IDX_W)
    ) u_base (
        .clk    (clk),
        .wr_en  (wr_en),
        .idx    (idx_q),
        .wr_ppn (ppn_q),
        .rd_ppn (base_rd)
    );

    always_comb begin
        unique case (kind_q)
            ACC_STORE: hit = (rd_tag[SLOT_STOR] == probe_tag);
            ACC_FETCH: hit = (rd_tag[SLOT_INSN] == probe_tag);
            default:   hit = (rd_tag[SLOT_LOAD] == probe_tag);
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_PROBE;
            ST_PROBE: begin
                if (hit)         state_d = ST_IDLE;
                else if (bypass) state_d = ST_FILL;
                else             state_d = ST_WALK;
            end
            ST_WALK:  if (walk_done) state_d = ST_FILL;
            ST_FILL:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and entry holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            kind_q  <= ACC_LOAD;
            priv_q  <= PRIV_U;
            mprv_q  <= PRIV_U;
            bare_q  <= 1'b0;
            ppn_q   <= '0;
            flags_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                vaddr_q <= req_vaddr;
                kind_q  <= req_kind;
                priv_q  <= st_priv;
                mprv_q  <= st_mprv;
                bare_q  <= st_bare;
            end
            if (state_q == ST_PROBE && !hit && bypass) begin
                ppn_q   <= syn_ppn;
                flags_q <= syn_flags;
            end
            if (state_q == ST_WALK && walk_done) begin
                ppn_q   <= walk_pte[ADDR_W-1:PG_SHIFT];
                flags_q <= walk_pte[PG_SHIFT-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        req_ready       = 1'b0;
        resp_valid      = 1'b0;
        resp_paddr      = '0;
        resp_fault      = 1'b0;
        resp_fault_kind = kind_q;
        walk_req        = 1'b0;
        walk_vaddr      = vaddr_q;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_PROBE: begin
                resp_valid = hit;
                resp_paddr = hit ? {base_rd, off_q} : '0;
            end
            ST_WALK:  walk_req = 1'b1;
            ST_FILL:  begin
                resp_valid = 1'b1;
                resp_fault = !fill_ok;
                resp_paddr = fill_ok ? {ppn_q, off_q} : '0;
            end
            default: ;
        endcase
    end

    // R1: a hit answers without involving the walker and frees the port
    a_r1_hit_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE && hit) |=> (!walk_req && req_ready));

    // R2: nothing hits in the cycle after a flush
    a_r2_flush_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);

    // R7: a fault leaves the same access missing
    a_r7_fault_keeps_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |=> !hit);

    // R9: a refill by a non-store leaves the store tag invalid
    a_r9_store_tag_only_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind_q != ACC_STORE && !flush) |=> (rd_tag[SLOT_STOR] == '1));

    // R11: the walker request holds with a stable address until answered
    a_r11_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_done) |=> (walk_req && $stable(walk_vaddr)));

    // R12: a response never coincides with readiness for a new request
    a_r12_busy_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

endmodule

// File: tb/tb_split_tlb.sv
module tb_split_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 24;
    localparam int PGS = 12;
    localparam int NE  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_vaddr = '0;
    logic [1:0]    req_kind = 2'd0;
    logic [1:0]    st_priv = 2'd0;
    logic [1:0]    st_mprv = 2'd0;
    logic          st_bare = 1'b0;
    logic          resp_valid;
    logic [AW-1:0] resp_paddr;
    logic          resp_fault;
    logic [1:0]    resp_fault_kind;
    logic          walk_req;
    logic [AW-1:0] walk_vaddr;
    logic          walk_done = 1'b0;
    logic [AW-1:0] walk_pte = '0;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    logic [12:0] m_tag [3][NE];
    logic [11:0] m_base [NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    split_tlb #(.ADDR_W(AW), .PG_SHIFT(PGS), .ENTRIES(NE)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind),
        .st_priv(st_priv), .st_mprv(st_mprv), .st_bare(st_bare),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .resp_fault_kind(resp_fault_kind),
        .walk_req(walk_req), .walk_vaddr(walk_vaddr),
        .walk_done(walk_done), .walk_pte(walk_pte)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // walker model: zero entries, entries without the valid bit, mixed permissions
    function automatic logic [AW-1:0] walk_fn(input logic [11:0] v);
        logic [6:0] p;
        if (v % 7 == 3) return '0;
        p = 7'((int'(v) * 37 + 5)) | 7'd1;
        if (v % 11 == 5) p[0] = 1'b0;
        return {v ^ 12'hA5C, 5'b0, p};
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 3; k++)
            for (int e = 0; e < NE; e++) m_tag[k][e] = '1;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_clear();
    endtask

    task automatic access(input logic [AW-1:0] va, input logic [1:0] kind);
        logic [11:0] vpn;
        int idx, ks, walks, exp_walks;
        bit got, is_s, is_m, dsup, byp, hit, ok;
        logic [6:0] need, fl;
        logic [AW-1:0] pte, exp_pa;
        string tag;
        vpn = va[23:12];
        idx = int'(vpn) % NE;
        ks  = (kind == 2'd1) ? 1 : (kind == 2'd2) ? 2 : 0;
        hit = (m_tag[ks][idx] == {1'b0, vpn});
        is_s = (st_priv == 2'd1);
        is_m = (st_priv == 2'd3);
        dsup = is_s || (is_m && st_mprv == 2'd1);
        need = '0;
        if (kind == 2'd1) need[dsup ? 5 : 2] = 1'b1;       // R3 store
        else if (kind == 2'd2) need[is_s ? 6 : 3] = 1'b1;  // R4 fetch
        else need[dsup ? 4 : 1] = 1'b1;                    // R3 load
        byp = st_bare || (is_m && (st_mprv == 2'd3 || kind == 2'd2)); // R5
        if (byp) begin                                               // R6
            fl = 7'b1001001;
            if (st_bare || !is_m || st_mprv == 2'd3) fl |= 7'b0110110;
            pte = {vpn, 5'b0, fl};
        end else begin
            pte = walk_fn(vpn);
        end
        fl = pte[6:0];
        ok = fl[0] && ((fl & need) != 0);
        exp_walks = (hit || byp) ? 0 : 1;
        if (hit) tag = "R1";
        else if (!ok) tag = "R7";
        else if (kind == 2'd1) tag = "R9";
        else if (byp) tag = "R6";
        else tag = "R8";
        exp_pa = hit ? {m_base[idx], va[11:0]} : (ok ? {pte[23:12], va[11:0]} : '0);

        req_vaddr = va; req_kind = kind; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        walks = 0; got = 0;
        for (int n = 0; n < 40 && !got; n++) begin
            if (resp_valid) begin
                got = 1;
                chk(req_ready == 1'b0, "R12 busy at response", 32'(req_ready), 0);
                chk(resp_fault == (!hit && !ok), {tag, " fault"}, 32'(resp_fault), 32'(!hit && !ok));
                if (!hit && !ok)
                    chk(resp_fault_kind == kind, "R7 fault kind", 32'(resp_fault_kind), 32'(kind));
                else
                    chk(resp_paddr == exp_pa, {tag, " R10 paddr"}, 32'(resp_paddr), 32'(exp_pa));
            end else if (walk_req) begin
                walks++;
                chk(walk_vaddr == va, "R11 walk address", 32'(walk_vaddr), 32'(va));
                walk_pte = walk_fn(walk_vaddr[23:12]);
                walk_done = 1'b1;
                @(negedge clk);
                walk_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        if (!got) chk(1'b0, {tag, " no response"}, 0, 1);
        chk(walks == exp_walks, {tag, " R5 walk count"}, 32'(walks), 32'(exp_walks));
        @(negedge clk);
        // model update for successful refills (R8, R9)
        if (!hit && ok) begin
            m_base[idx] = pte[23:12];
            m_tag[0][idx] = (fl[1] | fl[4]) ? {1'b0, vpn} : '1;
            m_tag[1][idx] = ((fl[2] | fl[5]) && kind == 2'd1) ? {1'b0, vpn} : '1;
            m_tag[2][idx] = (fl[3] | fl[6]) ? {1'b0, vpn} : '1;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [11:0] vpns [8];
        logic [1:0]  privs [3];
        vpns = '{12'h000, 12'h001, 12'h004, 12'h005, 12'h00A, 12'h010, 12'h803, 12'hFFF};
        privs = '{2'd0, 2'd1, 2'd3};
        model_clear();
        for (int e = 0; e < NE; e++) m_base[e] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(req_ready == 1'b1, "R12 reset ready", 32'(req_ready), 1);
        chk(resp_valid == 1'b0, "R12 reset resp", 32'(resp_valid), 0);
        chk(walk_req == 1'b0, "R12 reset walk", 32'(walk_req), 0);

        // R2: a load hit before a flush becomes a walk after it
        st_priv = 2'd1; st_mprv = 2'd0; st_bare = 1'b0;
        access({12'h001, 12'h123}, 2'd0);
        access({12'h001, 12'h124}, 2'd0);
        do_flush();
        access({12'h001, 12'h125}, 2'd0);

        for (int b = 0; b < 2; b++)
            for (int pi = 0; pi < 3; pi++)
                for (int mi = 0; mi < 3; mi++) begin
                    st_bare = b[0]; st_priv = privs[pi]; st_mprv = privs[mi];
                    for (int v = 0; v < 8; v++)
                        for (int k = 0; k < 3; k++) begin
                            access({vpns[v], 12'((v * 13 + k * 7 + pi) & 12'hFFF)}, 2'(k));
                            access({vpns[v], 12'((v * 29 + k * 5 + mi) & 12'hFFF)}, 2'(k));
                        end
                    // store after load on the same page (R9)
                    access({12'h001, 12'h040}, 2'd0);
                    access({12'h001, 12'h044}, 2'd1);
                    do_flush();
                end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule